// File: doc/BRIEF.md
# Three-Bus Register File With Instruction Decode

This block holds the eight general-purpose registers of a datapath organised around three buses. It has two read ports, one for each source bus, and one write port that is loaded from the result bus. All three register selectors are derived inside the block from the 32-bit instruction word. The control sequencer only supplies three enables: drive source bus one, drive source bus two, and write from the result bus.

The destination selector is taken from instruction bits 25:23, and the second source selector from bits 22:20. The first source selector normally comes from bits 19:17. When the opcode in bits 31:27 is the store-register code 5'b01101, it comes from bits 25:23 instead, so that the register being stored can travel on source bus one while the index register uses source bus two.

Register 0 is a constant zero. A source bus whose enable is low outputs all zeros, so it can be merged with other drivers by OR. Reads are combinational from the stored state. A write lands on the clock edge, so a read in the same cycle as a write returns the old value.

This block has no state machine. It is pure storage plus combinational selection. Its only sequential behaviour is the per-register load and the synchronous reset.

Top module: `tribus_regfile`

## Requirements
- R1: A synchronous active-high reset clears every register to zero. After reset, any read of any register returns 0.
- R2: While rd1_en is 1, b1_bus equals the register chosen by the first source selector.
- R3: The first source selector is ir[25:23] when ir[31:27] == 5'b01101, and ir[19:17] for every other opcode.
- R4: While rd2_en is 1, b2_bus equals the register whose index is ir[22:20].
- R5: When wr_en is 1 at a rising clock edge, the register whose index is ir[25:23] is loaded with b3_bus. No other register changes.
- R6: Register 0 always reads as 0, and a write addressed to index 0 is ignored.
- R7: While a read enable is 0, its bus outputs all zeros.
- R8: A read of a register in the same cycle as a write to it returns the old value. The new value is returned from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ir | input | 32 | Instruction word from which all selectors are derived |
| rd1_en | input | 1 | Drive source bus one from the register file |
| rd2_en | input | 1 | Drive source bus two from the register file |
| wr_en | input | 1 | Load the destination register from the result bus |
| b3_bus | input | 32 | Result bus data to be written |
| b1_bus | output | 32 | Source bus one, zero when rd1_en is low |
| b2_bus | output | 32 | Source bus two, zero when rd2_en is low |

## Verification
A corrupted register, or a write steered to the wrong index, stays hidden until that register is next read. It then appears on b1_bus or b2_bus as a value that differs from the last value written there. The bench therefore reads every register back, on both buses, after writes and after reset.

A decode fault in the store-register selector shows in the same cycle as that opcode, as a b1_bus value that comes from the wrong field. The bench aligns the two selectors so that b1_bus and b2_bus must then agree. A forwarding or timing fault shows as the new value appearing one cycle early, in the cycle of the write itself.

// File: rtl/tribus_regfile_pkg.sv
package tribus_regfile_pkg;
    localparam int IR_W      = 32;
    localparam int SEL_W     = 3;
    localparam int NUM_REGS  = 1 << SEL_W;
    localparam int OP_MSB    = 31;
    localparam int OP_W      = 5;
    localparam int FA_LSB    = 23;   // destination / store source field
    localparam int FB_LSB    = 20;   // second source / index field
    localparam int FC_LSB    = 17;   // first source field
    localparam logic [OP_W-1:0] OP_STORE = 5'b01101;

    typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/tribus_sel_decode.sv
module tribus_sel_decode
    import tribus_regfile_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    input  sel_t            fld_a,
    input  sel_t            fld_b,
    input  sel_t            fld_c,
    output sel_t            sel_src1,
    output sel_t            sel_src2,
    output sel_t            sel_dst
);
    always_comb begin
        sel_dst  = fld_a;
        sel_src2 = fld_b;
        unique case (opcode == OP_STORE)
            1'b1:    sel_src1 = fld_a;
            default: sel_src1 = fld_c;
        endcase
    end
endmodule

// File: rtl/tribus_reg_store.sv
module tribus_reg_store
    import tribus_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  sel_t              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_all [NUM_REGS]
);
    assign rd_all[0] = '0;

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_sel == sel_t'(g))) begin
                q <= wr_data;
            end
        end
        assign rd_all[g] = q;
    end
endmodule

// File: rtl/tribus_read_port.sv
module tribus_read_port
    import tribus_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              en,
    input  sel_t              sel,
    input  logic [DATA_W-1:0] rd_all [NUM_REGS],
    output logic [DATA_W-1:0] bus
);
    always_comb begin
        bus = '0;
        if (en) begin
            bus = rd_all[sel];
        end
    end
endmodule

// File: rtl/tribus_regfile.sv
module tribus_regfile
    import tribus_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   ir,
    input  logic              rd1_en,
    input  logic              rd2_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] b3_bus,
    output logic [DATA_W-1:0] b1_bus,
    output logic [DATA_W-1:0] b2_bus
);
    localparam int NUM_RD = 2;

    sel_t              sel_src1, sel_src2, sel_dst;
    sel_t              rd_sel [NUM_RD];
    logic              rd_en  [NUM_RD];
    logic [DATA_W-1:0] rd_bus [NUM_RD];
    logic [DATA_W-1:0] rd_all [NUM_REGS];
    logic              unused_ir;

    assign unused_ir = ^{ir[FA_LSB+SEL_W], ir[FC_LSB-1:0]};

    tribus_sel_decode u_dec (
        .opcode   (ir[OP_MSB -: OP_W]),
        .fld_a    (ir[FA_LSB +: SEL_W]),
        .fld_b    (ir[FB_LSB +: SEL_W]),
        .fld_c    (ir[FC_LSB +: SEL_W]),
        .sel_src1 (sel_src1),
        .sel_src2 (sel_src2),
        .sel_dst  (sel_dst)
    );

    tribus_reg_store #(.DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (sel_dst),
        .wr_data (b3_bus),
        .rd_all  (rd_all)
    );

    assign rd_sel[0] = sel_src1;
    assign rd_sel[1] = sel_src2;
    assign rd_en[0]  = rd1_en;
    assign rd_en[1]  = rd2_en;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        tribus_read_port #(.DATA_W(DATA_W)) u_port (
            .en     (rd_en[p]),
            .sel    (rd_sel[p]),
            .rd_all (rd_all),
            .bus    (rd_bus[p])
        );
    end

    assign b1_bus = rd_bus[0];
    assign b2_bus = rd_bus[1];
endmodule

// File: rtl/tribus_regfile_chk.sv
module tribus_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [31:0]       ir,
    input logic              rd1_en,
    input logic              rd2_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] b3_bus,
    input logic [DATA_W-1:0] b1_bus,
    input logic [DATA_W-1:0] b2_bus
);
    logic seen_rst = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) seen_rst <= 1'b1;
    end

    assert_bus1_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !rd1_en |-> b1_bus == '0);

    assert_bus2_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !rd2_en |-> b2_bus == '0);

    assert_zero_reg_R6: assert property (@(posedge clk) disable iff (rst)
        (rd2_en && ir[22:20] == 3'd0) |-> b2_bus == '0);

    assert_store_sel_R3: assert property (@(posedge clk) disable iff (rst)
        (rd1_en && rd2_en && ir[31:27] == 5'b01101 && ir[25:23] == ir[22:20])
        |-> b1_bus == b2_bus);

    assert_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        (seen_rst && $past(rst) && rd2_en) |-> b2_bus == '0);

    assert_write_seen_R5: assert property (@(posedge clk) disable iff (rst)
        (seen_rst && $past(seen_rst) && !$past(rst) && $past(wr_en)
         && $past(ir[25:23]) != 3'd0 && rd2_en && ir[22:20] == $past(ir[25:23]))
        |-> b2_bus == $past(b3_bus));
endmodule

bind tribus_regfile tribus_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ir     (ir),
    .rd1_en (rd1_en),
    .rd2_en (rd2_en),
    .wr_en  (wr_en),
    .b3_bus (b3_bus),
    .b1_bus (b1_bus),
    .b2_bus (b2_bus)
);

// File: tb/tribus_regfile_tb.sv
module tribus_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] OP_STR = 5'b01101;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic [31:0] ir = '0;
    logic        rd1_en = 1'b0, rd2_en = 1'b0, wr_en = 1'b0;
    logic [31:0] b3_bus = '0;
    logic [31:0] b1_bus, b2_bus;

    logic [31:0] model [8];
    int n_checks = 0;
    int n_fail   = 0;

    tribus_regfile u_dut (
        .clk(clk), .rst(rst), .ir(ir), .rd1_en(rd1_en), .rd2_en(rd2_en),
        .wr_en(wr_en), .b3_bus(b3_bus), .b1_bus(b1_bus), .b2_bus(b2_bus)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk_ir(logic [4:0] op, logic [2:0] a,
                                          logic [2:0] b, logic [2:0] c);
        return {op, 1'b0, a, b, c, 17'h0};
    endfunction

    function automatic logic [2:0] exp_sel1(logic [31:0] w);
        return (w[31:27] == OP_STR) ? w[25:23] : w[19:17];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic [31:0] w, logic e1, logic e2, logic ew,
                        logic [31:0] d, string t1, string t2);
        @(negedge clk);
        ir = w; rd1_en = e1; rd2_en = e2; wr_en = ew; b3_bus = d;
        #1;
        check(t1, b1_bus, e1 ? model[exp_sel1(w)] : 32'h0);
        check(t2, b2_bus, e2 ? model[w[22:20]] : 32'h0);
        @(posedge clk);
        if (ew && w[25:23] != 3'd0) model[w[25:23]] = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd1_en = 1'b0; rd2_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        for (int i = 0; i < 8; i++) model[i] = '0;
        do_reset();
        // R1: every register reads zero after reset
        for (int i = 0; i < 8; i++)
            step(mk_ir(5'b10101, 3'd0, 3'(i), 3'(i)), 1, 1, 0, 0, "R1", "R1");
        // R5: fill every register, including an attempt on r0
        for (int i = 0; i < 8; i++)
            step(mk_ir(5'b10101, 3'(i), 3'd0, 3'd0), 0, 0, 1,
                 32'hA5000000 | 32'(i * 17), "R7", "R7");
        // R2 and R4: read back on both buses; R6 for index 0
        for (int i = 0; i < 8; i++)
            step(mk_ir(5'b10110, 3'd0, 3'(i), 3'(7 - i)), 1, 1, 0, 0,
                 (i == 7) ? "R6" : "R2", (i == 0) ? "R6" : "R4");
        // R3: store opcode takes the first source from the destination field
        for (int i = 0; i < 8; i++)
            step(mk_ir(OP_STR, 3'(i), 3'(i), 3'(7 - i)), 1, 1, 0, 0, "R3", "R4");
        // R6: write to r0 is ignored
        step(mk_ir(5'b00001, 3'd0, 3'd0, 3'd0), 0, 0, 1, 32'hFFFFFFFF, "R7", "R7");
        step(mk_ir(5'b10101, 3'd0, 3'd0, 3'd0), 1, 1, 0, 0, "R6", "R6");
        // R8: read during write returns the old value, new one next cycle
        step(mk_ir(5'b10101, 3'd5, 3'd5, 3'd5), 1, 1, 1, 32'h12345678, "R8", "R8");
        step(mk_ir(5'b10101, 3'd0, 3'd5, 3'd5), 1, 1, 0, 0, "R8", "R8");
        check("R8", b2_bus, 32'h12345678);
        // random mix
        for (int k = 0; k < 600; k++) begin
            logic [31:0] w;
            w = $urandom();
            if (k % 4 == 0) w[31:27] = OP_STR;
            step(w, 1'($urandom()), 1'($urandom()), 1'($urandom()), $urandom(),
                 "R2", "R4");
        end
        // R1: reset again after random traffic
        do_reset();
        for (int i = 0; i < 8; i++)
            step(mk_ir(5'b11000, 3'd0, 3'(i), 3'(i)), 1, 1, 0, 0, "R1", "R1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule